// File: doc/BRIEF.md
# Programmable Chip Select Decoder

The block watches a 24-bit CPU address together with two cycle-type strobes, one for memory cycles and one for I/O cycles. From these it drives four active-low chip-select lines, and each line belongs to one configurable channel. A channel is set up either as a memory-range window or as an I/O port match.

In memory mode, a channel compares the top address byte against an inclusive lower and upper bound. In I/O mode, it compares address bits 15:8 for exact equality with its lower-bound byte, and the top byte plays no part. I/O addresses 0080h through 00FFh belong to on-chip peripherals, so no I/O-mode channel ever selects there. When more than one channel matches, the lowest-numbered one wins.

Software loads the configuration through a synchronous byte-write port. The decode is combinational, and the chip-select outputs are registered, so every select appears exactly one clock after the address and strobes that caused it.

Top module: `cs_decoder`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) drives all cs_n bits high at that edge and clears every channel's enable bit. Until software writes an enable, no select asserts, whatever the requests.
- R2: An enabled memory-mode channel matches when mem_req is 1 and addr[23:16] lies within its bounds: at least its lower byte and at most its upper byte, both ends inclusive.
- R3: An enabled I/O-mode channel matches when io_req is 1 and addr[15:8] equals its lower byte. Bits 23:16 and the upper byte are ignored.
- R4: An I/O-mode channel never matches while addr[15:0] is within 0080h..00FFh inclusive.
- R5: A memory-mode channel ignores io_req and an I/O-mode channel ignores mem_req. When both strobes are high, each channel uses its own strobe.
- R6: When several channels match, only the lowest-numbered one drives its cs_n bit low. At most one cs_n bit is low at any time.
- R7: A channel whose enable bit is 0 never asserts its select.
- R8: When mem_req and io_req are both 0, every cs_n bit is high on the following clock.
- R9: cs_n in the cycle after a clock edge reflects the address, strobes and configuration present just before that edge, which is a latency of one cycle. A configuration write takes effect for decodes from the next edge onward.
- R10: When wr_en is 1 at a clock edge, the register picked by wr_sel in channel wr_chan is loaded. The wr_sel codes are 0 for control, 1 for lower bound and 2 for upper bound. In the control byte, bit 3 is the enable and bit 4 selects I/O mode (1) or memory mode (0); its other bits are ignored. A write with wr_sel = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_chan | input | 2 | Channel index for the write |
| wr_sel | input | 2 | Register selector: 0 control, 1 lower, 2 upper, 3 none |
| wr_data | input | 8 | Write data byte |
| addr | input | 24 | CPU address |
| mem_req | input | 1 | Memory cycle in progress |
| io_req | input | 1 | I/O cycle in progress |
| cs_n | output | 4 | Active-low chip selects, bit i for channel i |

## Verification
The bench builds the decoder with its default parameters: four channels, a 24-bit address, a 16-bit I/O space and the peripheral window fixed at 0080h..00FFh. With four channels, every priority combination of overlapping windows can be reached, along with both edges of the reserved window and the exact boundaries of each memory range. A behavioural model in the bench predicts cs_n on every clock, including clocks where a write and a decode coincide. It is driven first by directed sequences and then by a long random stream of addresses, strobes and writes.

// File: rtl/csd_pkg.sv
// Package: shared types and constants of the chip-select decoder.
// Assumes byte-wide bound registers and a 2-bit register selector.
package csd_pkg;

    // Per-channel configuration as held in the register file.
    typedef struct packed {
        logic       en;
        logic       io;
        logic [7:0] lo;
        logic [7:0] hi;
    } csd_chan_cfg_t;

    // Register selector codes on the write port.
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LO    = 2'd1,
        SEL_HI    = 2'd2,
        SEL_NONE  = 2'd3
    } csd_sel_e;

    // Bit positions inside the control byte.
    localparam int CTRL_EN_BIT = 3;
    localparam int CTRL_IO_BIT = 4;

endpackage

// File: rtl/csd_cfg_regs.sv
// Module: configuration register file, one control/lower/upper set per
// channel. Assumes a single synchronous write port. Enables clear on reset.
module csd_cfg_regs
    import csd_pkg::*;
#(
    parameter int NUM_CH   = 4,
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CH_IDX_W-1:0] wr_chan,
    input  logic [1:0]          wr_sel,
    input  logic [7:0]          wr_data,
    output csd_chan_cfg_t       cfg [NUM_CH]
);

    csd_chan_cfg_t cfg_q [NUM_CH];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            // Load this channel's selected register on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[gi] <= '0;
                end else if (wr_en && (int'(wr_chan) == gi)) begin
                    case (csd_sel_e'(wr_sel))
                        SEL_CTRL: begin
                            cfg_q[gi].en <= wr_data[CTRL_EN_BIT];
                            cfg_q[gi].io <= wr_data[CTRL_IO_BIT];
                        end
                        SEL_LO:   cfg_q[gi].lo <= wr_data;
                        SEL_HI:   cfg_q[gi].hi <= wr_data;
                        default:  ;
                    endcase
                end
            end

            assign cfg[gi] = cfg_q[gi];

            // R1: reset leaves every channel disabled.
            a_r1_reset_disables: assert property (
                @(posedge clk) !rst_n |=> !cfg_q[gi].en
            ) else $error("R1: channel %0d enabled after reset", gi);

            // R10: a selector-3 write leaves this channel untouched.
            a_r10_sel_none_inert: assert property (
                @(posedge clk) disable iff (!rst_n)
                (wr_en && int'(wr_chan) == gi && wr_sel == 2'd3)
                    |=> $stable(cfg_q[gi])
            ) else $error("R10: selector 3 changed channel %0d", gi);
        end
    endgenerate

endmodule

// File: rtl/csd_chan_match.sv
// Module: match logic of one channel. Memory mode compares the top address
// byte with inclusive bounds; I/O mode compares the I/O high byte with the
// lower bound and is blocked inside the on-chip peripheral window.
module csd_chan_match
    import csd_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          IO_W      = 16,
    parameter logic [15:0] PERIPH_LO = 16'h0080,
    parameter logic [15:0] PERIPH_HI = 16'h00FF
) (
    input  csd_chan_cfg_t     cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_req,
    input  logic              io_req,
    output logic              hit
);

    localparam int MEM_TOP = ADDR_W - 1;
    localparam int IO_TOP  = IO_W - 1;

    logic [7:0]      mem_byte;
    logic [7:0]      io_byte;
    logic [IO_W-1:0] io_addr;
    logic            in_periph;
    logic            mem_hit;
    logic            io_hit;

    assign mem_byte = addr[MEM_TOP -: 8];
    assign io_byte  = addr[IO_TOP -: 8];
    assign io_addr  = addr[IO_W-1:0];

    // Decode the reserved peripheral window and both kinds of match.
    always_comb begin
        in_periph = (io_addr >= IO_W'(PERIPH_LO)) && (io_addr <= IO_W'(PERIPH_HI));
        mem_hit   = mem_req && (mem_byte >= cfg.lo) && (mem_byte <= cfg.hi);
        io_hit    = io_req && (io_byte == cfg.lo) && !in_periph;
        hit       = cfg.en && (cfg.io ? io_hit : mem_hit);
    end

endmodule

// File: rtl/csd_prio_pick.sv
// Module: fixed-priority picker; the lowest-numbered raised hit wins.
// Output is one-hot or zero.
module csd_prio_pick #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] grant
);

    logic [NUM_CH:0] blocked;

    assign blocked[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_pick
            // Pass the hit only if no lower channel has already matched.
            assign grant[gi]     = hit[gi] & ~blocked[gi];
            assign blocked[gi+1] = blocked[gi] | hit[gi];
        end
    endgenerate

endmodule

// File: rtl/cs_decoder.sv
// Module: top of the programmable chip-select decoder. Combinational
// per-channel decode, fixed priority, then one output register.
// Assumes synchronous active-low reset and a free-running clock.
module cs_decoder
    import csd_pkg::*;
#(
    parameter int          NUM_CH    = 4,
    parameter int          ADDR_W    = 24,
    parameter int          IO_W      = 16,
    parameter logic [15:0] PERIPH_LO = 16'h0080,
    parameter logic [15:0] PERIPH_HI = 16'h00FF,
    localparam int         CH_IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CH_IDX_W-1:0] wr_chan,
    input  logic [1:0]          wr_sel,
    input  logic [7:0]          wr_data,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                mem_req,
    input  logic                io_req,
    output logic [NUM_CH-1:0]   cs_n
);

    csd_chan_cfg_t     cfg [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] grant;
    logic [NUM_CH-1:0] cs_n_q;

    csd_cfg_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_match
            csd_chan_match #(
                .ADDR_W    (ADDR_W),
                .IO_W      (IO_W),
                .PERIPH_LO (PERIPH_LO),
                .PERIPH_HI (PERIPH_HI)
            ) u_match (
                .cfg     (cfg[gi]),
                .addr    (addr),
                .mem_req (mem_req),
                .io_req  (io_req),
                .hit     (hit[gi])
            );

            // R5/R7: a low select traces back to an enabled channel and its own strobe.
            a_r5_strobe_matches_mode: assert property (
                @(posedge clk) disable iff (!rst_n)
                !cs_n[gi] |-> ($past(cfg[gi].en) &&
                               ($past(cfg[gi].io) ? $past(io_req) : $past(mem_req)))
            ) else $error("R5: channel %0d selected without its strobe", gi);
        end
    endgenerate

    csd_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .hit   (hit),
        .grant (grant)
    );

    // Register the active-low selects for a glitch-free, one-cycle output.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_n_q <= '1;
        else        cs_n_q <= ~grant;
    end

    assign cs_n = cs_n_q;

    // R1: outputs inactive after a reset edge.
    a_r1_reset_outputs: assert property (
        @(posedge clk) !rst_n |=> (cs_n == '1)
    ) else $error("R1: select active after reset");

    // R6: never more than one select low.
    a_r6_single_select: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)
    ) else $error("R6: multiple selects low");

    // R8: no request means no select on the next clock.
    a_r8_idle_quiet: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!mem_req && !io_req) |=> (cs_n == '1)
    ) else $error("R8: select without request");

    // R4: an I/O-only cycle in the peripheral window selects nothing.
    a_r4_periph_window: assert property (
        @(posedge clk) disable iff (!rst_n)
        (io_req && !mem_req &&
         addr[IO_W-1:0] >= IO_W'(PERIPH_LO) && addr[IO_W-1:0] <= IO_W'(PERIPH_HI))
            |=> (cs_n == '1)
    ) else $error("R4: select inside peripheral window");

endmodule

// File: tb/cs_decoder_tb.sv
// Bench: behavioural reference model updated on each rising edge, compared
// with cs_n on every falling edge. Directed phases, then a random stream.
module cs_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [23:0] addr = '0;
    logic        mem_req = 1'b0;
    logic        io_req = 1'b0;
    logic [3:0]  cs_n;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    cmp_on   = 1'b0;
    bit    done     = 1'b0;

    // Reference model state.
    bit       m_en [4];
    bit       m_io [4];
    bit [7:0] m_lo [4];
    bit [7:0] m_hi [4];
    bit [3:0] exp_cs = 4'hF;

    cs_decoder u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .addr    (addr),
        .mem_req (mem_req),
        .io_req  (io_req),
        .cs_n    (cs_n)
    );

    always #10 clk = ~clk;

    function automatic bit [3:0] ref_decode();
        int io16 = int'(addr[15:0]);
        for (int i = 0; i < 4; i++) begin
            bit h = 1'b0;
            if (m_en[i]) begin
                if (m_io[i])
                    h = io_req && (addr[15:8] == m_lo[i]) && !(io16 >= 'h80 && io16 <= 'hFF);
                else
                    h = mem_req && (addr[23:16] >= m_lo[i]) && (addr[23:16] <= m_hi[i]);
            end
            if (h) return ~(4'b1 << i);
        end
        return 4'hF;
    endfunction

    // Reference model: predict the next output, then apply any write.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_cs = 4'hF;
            for (int i = 0; i < 4; i++) m_en[i] = 1'b0;
        end else begin
            exp_cs = ref_decode();
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin m_en[wr_chan] = wr_data[3]; m_io[wr_chan] = wr_data[4]; end
                    2'd1: m_lo[wr_chan] = wr_data;
                    2'd2: m_hi[wr_chan] = wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Compare on every falling edge once the run is under way.
    always @(negedge clk) begin
        if (cmp_on) begin
            n_checks++;
            if (cs_n !== exp_cs) begin
                n_fail++;
                $display("FAIL %s: cs_n=%b expected=%b addr=%h mem=%b io=%b",
                         tag, cs_n, exp_cs, addr, mem_req, io_req);
            end
        end
    end

    task automatic bus(input logic [23:0] a, input logic m, input logic i);
        @(negedge clk);
        wr_en = 1'b0; addr = a; mem_req = m; io_req = i;
    endtask

    task automatic wr(input int ch, input int sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 2'(ch); wr_sel = 2'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg_ch(input int ch, input bit en, input bit io,
                          input logic [7:0] lo, input logic [7:0] hi);
        wr(ch, 1, lo);
        wr(ch, 2, hi);
        wr(ch, 0, {3'b000, io, en, 3'b000});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state checked before any configuration.
        n_checks++;
        if (cs_n !== 4'hF) begin
            n_fail++;
            $display("FAIL R1: cs_n=%b expected=1111 during reset", cs_n);
        end
        rst_n = 1'b1;
        cmp_on = 1'b1;

        tag = "R1";
        bus(24'h123456, 1, 0); bus(24'h001200, 0, 1); bus(24'hFFFFFF, 1, 1);

        tag = "R2";
        cfg_ch(0, 1, 0, 8'h00, 8'h7F);
        cfg_ch(1, 1, 0, 8'h80, 8'h9F);
        cfg_ch(2, 1, 0, 8'hA0, 8'hCF);
        cfg_ch(3, 1, 0, 8'hD0, 8'hFF);
        foreach (m_lo[k]) begin
            bus({m_lo[k], 16'h0000}, 1, 0);
            bus({m_hi[k], 16'hFFFF}, 1, 0);
        end
        bus(24'h7FFFFF, 1, 0); bus(24'h800000, 1, 0);
        bus(24'h9FFFFF, 1, 0); bus(24'hA00000, 1, 0);

        tag = "R5";
        bus(24'h400000, 0, 1);
        tag = "R8";
        bus(24'h400000, 0, 0); bus(24'hD00000, 0, 0);

        tag = "R3";
        cfg_ch(2, 1, 1, 8'h12, 8'h00);
        bus(24'h001234, 0, 1); bus(24'hFF1200, 0, 1); bus(24'h001334, 0, 1);
        tag = "R5";
        bus(24'hA01234, 1, 0); bus(24'h0F1234, 1, 1);

        tag = "R4";
        cfg_ch(3, 1, 1, 8'h00, 8'h00);
        bus(24'h00007F, 0, 1); bus(24'h000080, 0, 1);
        bus(24'hAB00FF, 0, 1); bus(24'h000000, 0, 1);

        tag = "R6";
        cfg_ch(1, 1, 0, 8'h00, 8'hFF);
        bus(24'h100000, 1, 0); bus(24'hF00000, 1, 0);
        wr(0, 0, 8'h00);
        bus(24'h100000, 1, 0);

        tag = "R7";
        wr(1, 0, 8'hF7);
        bus(24'h100000, 1, 0); bus(24'hE00000, 1, 0);

        tag = "R10";
        wr(1, 3, 8'hFF);
        bus(24'h100000, 1, 0);
        wr(3, 0, 8'hE7);
        bus(24'h000055, 0, 1); bus(24'h001200, 0, 1);

        tag = "R9";
        // Write lands on the same edge as a decode: old config applies to it.
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 2'd0; wr_sel = 2'd0; wr_data = 8'h08;
        addr = 24'h050000; mem_req = 1'b1; io_req = 1'b0;
        bus(24'h050000, 1, 0);
        bus(24'h060000, 0, 0);

        tag = "R6";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 9) == 0) begin
                logic [7:0] d = 8'($urandom);
                wr($urandom_range(0, 3), $urandom_range(0, 3),
                   ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 2)) << 3 : d);
            end else begin
                logic [23:0] a = 24'($urandom);
                if ($urandom_range(0, 3) == 0) a[15:8] = 8'($urandom_range(0, 2));
                bus(a, 1'($urandom), 1'($urandom));
            end
        end

        bus(24'h0, 0, 0);
        @(negedge clk);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule